// File: doc/BRIEF.md
# Transparent Read Bypass Around a Synchronous RAM

This block takes a plain synchronous RAM whose registered read port returns the old word whenever a write hits the same address in the same cycle. It wraps that port so the read data behaves as write-first, meaning transparent, with respect to every write port. Each write port gets a bypass stage.

The stage registers the write data and registers a per-lane hit flag. The hit flag is the lane's byte enable ANDed with an address compare. An output multiplexer then picks either the RAM word or the registered write lane. The hit flags copy the read port's clock enable and both of its resets, so the bypass never outlives or precedes the read it patches.

Stages are chained from the lowest-priority write port to the highest. The last stage therefore decides a lane when two ports write the same lane of the read address in the same cycle. This matches the RAM, where the higher-numbered port also wins. All ports share one clock.

Top module: `tbyp_wrap`

## Requirements
- R1: While `rst_n` is low, and after it is released, `rd_data` is all zeros until the first enabled read.
- R2: A read with `rd_en` high and no write to the same address returns the stored word on `rd_data` one clock later.
- R3: When a write port writes all lanes of the address being read in the same cycle, `rd_data` shows the new data one clock later.
- R4: Lanes whose enable bit is low in a colliding write show the old stored contents. Lane `l` covers data bits `[l*LANE_W +: LANE_W]` and is controlled by `wr_be[p*LANES+l]` of port `p`.
- R5: A write to a different address than the one being read does not change the returned word.
- R6: When several ports write the same lane of the read address in one cycle, the port with the highest index supplies that lane, both in the bypass result and in the stored word.
- R7: With `rd_en` low and `rd_srst` low, `rd_data` holds its value, even while a write hits the read address.
- R8: `rd_srst` high forces `rd_data` to zero one clock later. With the default precedence this happens regardless of `rd_en`, and a colliding write in that cycle does not leak through.
- R9: Data written during a bypassed read is in the RAM, so a later read of that address returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the read port and all write ports |
| rst_n | input | 1 | Asynchronous active-low reset of the read side |
| rd_en | input | 1 | Read clock enable |
| rd_srst | input | 1 | Synchronous reset of the read data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Transparent read data |
| wr_addr | input | NUM_WR*ADDR_W | Write addresses, port p at `[p*ADDR_W +: ADDR_W]` |
| wr_data | input | NUM_WR*DATA_W | Write data, port p at `[p*DATA_W +: DATA_W]` |
| wr_be | input | NUM_WR*LANES | Per-lane write enables, port p at `[p*LANES +: LANES]` |

## Verification
A hit flag stuck high or low shows as a wrong lane on `rd_data` in the very cycle after the collision. A stale flag that failed to follow `rd_en` or `rd_srst` shows as registered write data leaking into a later, unrelated read. The captured write data is only observable through a hit, so errors there appear only on collisions. For that reason the random traffic keeps addresses in a small window, which makes collisions and two-port ties frequent. Priority mistakes between stages appear only when two ports hit the same lane, so those cases are forced directly as well.

// File: rtl/tbyp_pkg.sv
package tbyp_pkg;

  // Precedence between the read clock enable and the synchronous reset.
  typedef enum logic {
    SRST_WINS     = 1'b0,  // reset acts whatever rd_en is
    EN_GATES_SRST = 1'b1   // reset only acts in enabled cycles
  } srst_mode_e;

  function automatic logic srst_fires(srst_mode_e mode, logic srst, logic en);
    return srst && ((mode == SRST_WINS) || en);
  endfunction

endpackage

// File: rtl/tbyp_ram.sv
module tbyp_ram
  import tbyp_pkg::*;
#(
  parameter int         ADDR_W    = 4,
  parameter int         DATA_W    = 16,
  parameter int         LANE_W    = 8,
  parameter int         NUM_WR    = 2,
  parameter srst_mode_e SRST_MODE = SRST_WINS
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     rd_en,
  input  logic                     rd_srst,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [DATA_W-1:0]        rd_q,
  input  logic [NUM_WR*ADDR_W-1:0] wr_addr,
  input  logic [NUM_WR*DATA_W-1:0] wr_data,
  input  logic [NUM_WR*(DATA_W/LANE_W)-1:0] wr_be
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int LANES = DATA_W / LANE_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] q_r, q_nxt;

  // Later ports are assigned last, so the highest index wins a lane.
  always_ff @(posedge clk) begin
    for (int p = 0; p < NUM_WR; p++) begin
      for (int l = 0; l < LANES; l++) begin
        if (wr_be[p*LANES+l]) begin
          mem[wr_addr[p*ADDR_W +: ADDR_W]][l*LANE_W +: LANE_W] <=
            wr_data[p*DATA_W + l*LANE_W +: LANE_W];
        end
      end
    end
  end

  // Non-transparent registered read: old contents on a collision.
  always_comb begin
    q_nxt = q_r;
    if (srst_fires(SRST_MODE, rd_srst, rd_en)) begin
      q_nxt = '0;
    end else if (rd_en) begin
      q_nxt = mem[rd_addr];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= '0;
    end else begin
      q_r <= q_nxt;
    end
  end

  assign rd_q = q_r;

  // R7: the read register keeps its word in idle cycles.
  a_r7_ram_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && !rd_srst) |=> $stable(rd_q));

endmodule

// File: rtl/tbyp_hit_ff.sv
module tbyp_hit_ff
  import tbyp_pkg::*;
#(
  parameter srst_mode_e SRST_MODE = SRST_WINS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_en,
  input  logic rd_srst,
  input  logic hit_d,
  output logic hit_q
);
  logic hit_r, hit_nxt;

  // Same enable and reset behaviour as the read data register.
  always_comb begin
    hit_nxt = hit_r;
    if (srst_fires(SRST_MODE, rd_srst, rd_en)) begin
      hit_nxt = 1'b0;
    end else if (rd_en) begin
      hit_nxt = hit_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_r <= 1'b0;
    end else begin
      hit_r <= hit_nxt;
    end
  end

  assign hit_q = hit_r;

  // R7: a flag set by an earlier read must not change in idle cycles.
  a_r7_hit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en && !rd_srst) |=> $stable(hit_q));

  // R8: a firing synchronous reset leaves no pending bypass.
  a_r8_hit_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_srst && (SRST_MODE == SRST_WINS || rd_en)) |=> !hit_q);

endmodule

// File: rtl/tbyp_stage.sv
module tbyp_stage
  import tbyp_pkg::*;
#(
  parameter int         ADDR_W    = 4,
  parameter int         DATA_W    = 16,
  parameter int         LANE_W    = 8,
  parameter srst_mode_e SRST_MODE = SRST_WINS
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       rd_en,
  input  logic                       rd_srst,
  input  logic [ADDR_W-1:0]          rd_addr,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic [DATA_W/LANE_W-1:0]   wr_be,
  input  logic [DATA_W-1:0]          prev_data,
  output logic [DATA_W-1:0]          stage_data
);
  localparam int LANES = DATA_W / LANE_W;

  logic [DATA_W-1:0] wcap_q, wcap_nxt;
  logic              addr_eq;
  logic [LANES-1:0]  hit_q;

  // Captured write word; no reset, it is masked until a hit is set.
  always_comb wcap_nxt = rd_en ? wr_data : wcap_q;

  always_ff @(posedge clk) begin
    wcap_q <= wcap_nxt;
  end

  assign addr_eq = (rd_addr == wr_addr);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    tbyp_hit_ff #(
      .SRST_MODE(SRST_MODE)
    ) u_hit (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_en  (rd_en),
      .rd_srst(rd_srst),
      .hit_d  (wr_be[l] & addr_eq),
      .hit_q  (hit_q[l])
    );

    assign stage_data[l*LANE_W +: LANE_W] =
      hit_q[l] ? wcap_q[l*LANE_W +: LANE_W] : prev_data[l*LANE_W +: LANE_W];
  end

endmodule

// File: rtl/tbyp_wrap.sv
module tbyp_wrap
  import tbyp_pkg::*;
#(
  parameter int         ADDR_W    = 4,
  parameter int         DATA_W    = 16,
  parameter int         LANE_W    = 8,
  parameter int         NUM_WR    = 2,
  parameter srst_mode_e SRST_MODE = SRST_WINS
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              rd_en,
  input  logic                              rd_srst,
  input  logic [ADDR_W-1:0]                 rd_addr,
  output logic [DATA_W-1:0]                 rd_data,
  input  logic [NUM_WR*ADDR_W-1:0]          wr_addr,
  input  logic [NUM_WR*DATA_W-1:0]          wr_data,
  input  logic [NUM_WR*(DATA_W/LANE_W)-1:0] wr_be
);
  localparam int LANES = DATA_W / LANE_W;
  localparam int TOP   = NUM_WR - 1;

  logic [DATA_W-1:0] chain [NUM_WR+1];
  logic [DATA_W-1:0] ram_q;

  tbyp_ram #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .LANE_W   (LANE_W),
    .NUM_WR   (NUM_WR),
    .SRST_MODE(SRST_MODE)
  ) u_ram (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_en  (rd_en),
    .rd_srst(rd_srst),
    .rd_addr(rd_addr),
    .rd_q   (ram_q),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .wr_be  (wr_be)
  );

  assign chain[0] = ram_q;

  // Lowest priority first; the last stage has the final say.
  for (genvar p = 0; p < NUM_WR; p++) begin : g_port
    tbyp_stage #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .LANE_W   (LANE_W),
      .SRST_MODE(SRST_MODE)
    ) u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_en     (rd_en),
      .rd_srst   (rd_srst),
      .rd_addr   (rd_addr),
      .wr_addr   (wr_addr[p*ADDR_W +: ADDR_W]),
      .wr_data   (wr_data[p*DATA_W +: DATA_W]),
      .wr_be     (wr_be[p*LANES +: LANES]),
      .prev_data (chain[p]),
      .stage_data(chain[p+1])
    );
  end

  assign rd_data = chain[NUM_WR];

  // R1: the first cycle out of reset presents zeros.
  a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (rd_data == '0));

  // R6: the highest-index port decides every lane it writes at the read address.
  for (genvar l = 0; l < LANES; l++) begin : g_chk
    a_r6_top_port_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && !rd_srst && wr_be[TOP*LANES+l] &&
       (wr_addr[TOP*ADDR_W +: ADDR_W] == rd_addr))
      |=> (rd_data[l*LANE_W +: LANE_W] ==
           $past(wr_data[TOP*DATA_W + l*LANE_W +: LANE_W])));
  end

endmodule

// File: tb/tbyp_wrap_tb.sv
`timescale 1ns/1ps
module tbyp_wrap_tb;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 16;
  localparam int LANE_W = 8;
  localparam int NUM_WR = 2;
  localparam int LANES  = DATA_W / LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic                        clk = 1'b0;
  logic                        rst_n;
  logic                        rd_en;
  logic                        rd_srst;
  logic [ADDR_W-1:0]           rd_addr;
  logic [DATA_W-1:0]           rd_data;
  logic [NUM_WR*ADDR_W-1:0]    wr_addr;
  logic [NUM_WR*DATA_W-1:0]    wr_data;
  logic [NUM_WR*LANES-1:0]     wr_be;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [DATA_W-1:0] mdl [DEPTH];
  logic [DATA_W-1:0] exp_q = '0;

  always #2.5 clk = ~clk;

  tbyp_wrap #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANE_W(LANE_W), .NUM_WR(NUM_WR)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_srst(rd_srst),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be)
  );

  task automatic check(input string tag, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    rd_en = 1'b0; rd_srst = 1'b0; wr_be = '0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic set_wr(input int p, input logic [ADDR_W-1:0] a,
                        input logic [DATA_W-1:0] d, input logic [LANES-1:0] be);
    wr_addr[p*ADDR_W +: ADDR_W] = a;
    wr_data[p*DATA_W +: DATA_W] = d;
    wr_be[p*LANES +: LANES]     = be;
  endtask

  // Reference: write-first transparent RAM, higher port index wins a lane.
  function automatic logic [DATA_W-1:0] fwd_word(input logic [DATA_W-1:0] base,
                                                 input logic [ADDR_W-1:0] a);
    logic [DATA_W-1:0] w = base;
    for (int p = 0; p < NUM_WR; p++)
      for (int l = 0; l < LANES; l++)
        if (wr_be[p*LANES+l] && wr_addr[p*ADDR_W +: ADDR_W] == a)
          w[l*LANE_W +: LANE_W] = wr_data[p*DATA_W + l*LANE_W +: LANE_W];
    return w;
  endfunction

  task automatic tick(input string tag, input bit chk);
    @(posedge clk);
    if (rd_srst) exp_q = '0;
    else if (rd_en) exp_q = fwd_word(mdl[rd_addr], rd_addr);
    for (int p = 0; p < NUM_WR; p++)
      for (int l = 0; l < LANES; l++)
        if (wr_be[p*LANES+l])
          mdl[wr_addr[p*ADDR_W +: ADDR_W]][l*LANE_W +: LANE_W] =
            wr_data[p*DATA_W + l*LANE_W +: LANE_W];
    @(negedge clk);
    if (chk) check(tag, rd_data, exp_q);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; rd_addr = '0; idle();
    repeat (4) @(negedge clk);
    check("R1 in reset", rd_data, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", rd_data, '0);

    // Fill memory with rd_en low: output must stay at zero (R7).
    for (int a = 0; a < DEPTH; a++) begin
      idle(); rd_addr = ADDR_W'(a);
      set_wr(0, ADDR_W'(a), DATA_W'(16'h1100 + a * 16'h0101), 2'b11);
      tick("R7 idle during fill", 1'b1);
    end

    // R2: plain read.
    idle(); rd_en = 1'b1; rd_addr = 4'd5;
    tick("R2 plain read", 1'b1);
    check("R2 value", rd_data, 16'h1605);

    // R3: full-lane collision.
    idle(); rd_en = 1'b1; rd_addr = 4'd3; set_wr(0, 4'd3, 16'hAAAA, 2'b11);
    tick("R3 full collision", 1'b1);
    check("R3 value", rd_data, 16'hAAAA);

    // R4: only lane 0 written.
    idle(); rd_en = 1'b1; rd_addr = 4'd7; set_wr(1, 4'd7, 16'h5566, 2'b01);
    tick("R4 partial collision", 1'b1);
    check("R4 value", rd_data, 16'h1866);

    // R5: write elsewhere.
    idle(); rd_en = 1'b1; rd_addr = 4'd9; set_wr(0, 4'd10, 16'hDEAD, 2'b11);
    tick("R5 other address", 1'b1);
    check("R5 value", rd_data, 16'h1A09);

    // R6: both ports on the same lanes; then split lanes.
    idle(); rd_en = 1'b1; rd_addr = 4'd2;
    set_wr(0, 4'd2, 16'h1234, 2'b11); set_wr(1, 4'd2, 16'h9876, 2'b11);
    tick("R6 tie", 1'b1);
    check("R6 tie value", rd_data, 16'h9876);
    idle(); rd_en = 1'b1; rd_addr = 4'd4;
    set_wr(0, 4'd4, 16'hC1C2, 2'b11); set_wr(1, 4'd4, 16'hE1E2, 2'b01);
    tick("R6 split", 1'b1);
    check("R6 split value", rd_data, 16'hC1E2);

    // R9: stored result of the bypassed writes.
    idle(); rd_en = 1'b1; rd_addr = 4'd2;
    tick("R9 stored", 1'b1);
    check("R9 value", rd_data, 16'h9876);

    // R7: rd_en low while a write hits the read address.
    idle(); rd_addr = 4'd2; set_wr(1, 4'd2, 16'h0F0F, 2'b11);
    tick("R7 hold", 1'b1);
    check("R7 value", rd_data, 16'h9876);

    // R8: reset with colliding write, then reset without enable.
    idle(); rd_en = 1'b1; rd_srst = 1'b1; rd_addr = 4'd6; set_wr(0, 4'd6, 16'h7777, 2'b11);
    tick("R8 srst with collision", 1'b1);
    check("R8 zero", rd_data, 16'h0000);
    idle(); rd_en = 1'b1; rd_addr = 4'd6;
    tick("R8 reload", 1'b1);
    idle(); rd_srst = 1'b1;
    tick("R8 srst without enable", 1'b1);
    check("R8 zero idle", rd_data, 16'h0000);

    // Random traffic in a small address window.
    for (int i = 0; i < 4000; i++) begin
      idle();
      rd_en   = ($urandom_range(0, 9) < 8);
      rd_srst = ($urandom_range(0, 99) < 3);
      rd_addr = ADDR_W'($urandom_range(0, 3));
      for (int p = 0; p < NUM_WR; p++)
        set_wr(p, ADDR_W'($urandom_range(0, 3)), DATA_W'($urandom),
               LANES'($urandom));
      tick("random R3/R4/R6", 1'b1);
    end

    idle();
    tick("final", 1'b0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule